// File: doc/BRIEF.md
# UART RTS/CTS Flow Control Unit

This unit runs the RTS/CTS handshake for a UART. The receive path drives the request-to-send pin from the receive FIFO's current fill level. The pin drops once the count reaches a programmable trigger level. When automatic RTS is switched off, the pin follows a software-owned bit instead. The transmit path sits between the TX FIFO and the serial shifter. It lets a new character start only while clear-to-send is active, no frame is in progress and the shifter is ready.

Each pin has its own polarity select. The CTS input goes through a two-flop synchronizer. A change in its synchronized level sets a sticky detect flag, which drives the modem interrupt until software clears it. Two status outputs return the synchronized CTS level and the level actually driven on the RTS pin.

The TX path is a valid/ready stream. `tx_fifo_valid` is the FIFO's not-empty signal. `tx_fifo_ready` pops one entry. `shift_valid` offers a character to the shifter, and `shift_ready` accepts it. A pop happens only in a cycle where the shifter accepts. The offer never depends on `shift_ready`. The shifter can hold off with `shift_ready` low for as long as it likes, and the FIFO entry stays in place.

Top module: `uart_flow_ctrl`

## Requirements
- R1: With automatic RTS on, the internal request is asserted while `rx_count` is below the effective trigger level and deasserted when `rx_count` equals or exceeds it. `rts_pin` shows the new value one clock after the inputs change.
- R2: A `rts_trig` value of 0 acts as a trigger level of 1, so the request drops with one byte held.
- R3: With automatic RTS off, the internal request equals `sw_rts`, and `rx_count` has no effect.
- R4: With `rts_invert` = 0 the pin equals the internal request (1 = asserted). With `rts_invert` = 1 the pin is its complement.
- R5: With `cts_act_high` = 0 a low CTS level counts as active. With `cts_act_high` = 1 a high level counts as active.
- R6: With `auto_cts_en` = 1, `shift_valid` and `tx_fifo_ready` stay 0 while the synchronized CTS is inactive. A pin change reaches the gate after two clocks. With `auto_cts_en` = 0, CTS is ignored.
- R7: No character is offered or popped while `tx_busy` = 1. A frame already in progress is never cut short by CTS.
- R8: Stream rule: `shift_valid` = `tx_fifo_valid` when the start is allowed, and does not depend on `shift_ready`. `tx_fifo_ready` is 1 only when `shift_valid` and `shift_ready` are both 1.
- R9: A change in the synchronized CTS level sets `cts_chg_flag` three clocks after the pin changes. The flag stays set and `modem_irq` equals it.
- R10: `flag_clr` = 1 clears the flag on the next clock. If a new change is seen in that same cycle, the flag stays set.
- R11: `cts_level` returns the synchronized raw CTS level two clocks after the pin changes. `rts_level` always equals `rts_pin`.
- R12: After reset, `rts_pin`, `cts_level` and `cts_chg_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| auto_rts_en | input | 1 | Drive RTS from the FIFO fill level |
| auto_cts_en | input | 1 | Gate character starts on CTS |
| rts_invert | input | 1 | Invert the internal request onto the pin |
| cts_act_high | input | 1 | CTS counts as active when high |
| sw_rts | input | 1 | Software request, used when automatic RTS is off |
| rts_trig | input | TRIG_W | Receive trigger level (0 treated as 1) |
| flag_clr | input | 1 | Clear the CTS change flag |
| rx_count | input | CNT_W | Bytes held in the RX FIFO |
| tx_fifo_valid | input | 1 | TX FIFO not empty |
| tx_fifo_ready | output | 1 | Pop one TX FIFO entry |
| shift_valid | output | 1 | Character offered to the shifter |
| shift_ready | input | 1 | Shifter accepts the character |
| tx_busy | input | 1 | Shifter has a frame in progress |
| cts_pin | input | 1 | Clear-to-send pin |
| rts_pin | output | 1 | Request-to-send pin |
| cts_chg_flag | output | 1 | Sticky CTS change flag |
| modem_irq | output | 1 | Modem interrupt |
| cts_level | output | 1 | Synchronized CTS level |
| rts_level | output | 1 | RTS pin level readback |

## Verification
The stream gate is combinational from its own inputs, so a change in `tx_busy`, `shift_ready`, the FIFO valid or a config bit is checked in the same low clock phase. The pin outputs change on different clocks. `rts_pin` and `rts_level` follow their inputs after one clock. A CTS pin change reaches `cts_level` and the gate after two clocks, and the change flag after three. The bench changes inputs on the falling edge and counts exactly that many rising edges before it samples on the next falling edge. For the CTS path it also samples one clock early, to show that the output has not moved yet.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;
  typedef enum logic {
    POL_ACT_LOW  = 1'b0,
    POL_ACT_HIGH = 1'b1
  } pol_e;

  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/fc_cts_sync.sv
module fc_cts_sync #(
  parameter int STAGES = uart_fc_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic level,
  output logic change
);
  logic [STAGES-1:0] chain;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= pin_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain[STAGES-1];

  assign level  = chain[STAGES-1];
  assign change = chain[STAGES-1] ^ prev_q;
endmodule

// File: rtl/fc_detect_flag.sv
module fc_detect_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;

  assign flag_o = flag_q;

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o);
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/fc_rts_gen.sv
module fc_rts_gen #(
  parameter int CNT_W  = 5,
  parameter int TRIG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_en,
  input  logic              invert,
  input  logic              sw_req,
  input  logic [TRIG_W-1:0] trig,
  input  logic [CNT_W-1:0]  count,
  output logic              pin_o
);
  localparam int CMP_W = (CNT_W > TRIG_W) ? CNT_W : TRIG_W;

  logic [CMP_W-1:0] eff_lvl, cnt_ext;
  logic             req, pin_q, past_ok;

  always_comb begin
    eff_lvl = CMP_W'(trig);
    if (trig == '0) eff_lvl = CMP_W'(1);
    cnt_ext = CMP_W'(count);
    req     = auto_en ? (cnt_ext < eff_lvl) : sw_req;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pin_q   <= 1'b0;
      past_ok <= 1'b0;
    end else begin
      pin_q   <= req ^ invert;
      past_ok <= 1'b1;
    end

  assign pin_o = pin_q;

  assert_full_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && !invert && count >= CNT_W'(trig) && count != '0) |=> !pin_o);
  assert_manual_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(auto_en)) |-> (pin_o == ($past(sw_req) ^ $past(invert))));
endmodule

// File: rtl/fc_tx_gate.sv
module fc_tx_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_en,
  input  logic cts_ok,
  input  logic tx_busy,
  input  logic in_valid,
  output logic in_ready,
  output logic out_valid,
  input  logic out_ready
);
  logic allow;

  always_comb begin
    allow     = (!auto_en || cts_ok) && !tx_busy;
    out_valid = in_valid && allow;
    in_ready  = out_valid && out_ready;
  end

  assert_no_start_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |-> (!out_valid && !in_ready));
  assert_pop_needs_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (out_ready && in_valid));
  assert_cts_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && !cts_ok) |-> !out_valid);
endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl #(
  parameter int CNT_W  = 5,
  parameter int TRIG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_rts_en,
  input  logic              auto_cts_en,
  input  logic              rts_invert,
  input  logic              cts_act_high,
  input  logic              sw_rts,
  input  logic [TRIG_W-1:0] rts_trig,
  input  logic              flag_clr,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic              tx_fifo_valid,
  output logic              tx_fifo_ready,
  output logic              shift_valid,
  input  logic              shift_ready,
  input  logic              tx_busy,
  input  logic              cts_pin,
  output logic              rts_pin,
  output logic              cts_chg_flag,
  output logic              modem_irq,
  output logic              cts_level,
  output logic              rts_level
);
  import uart_fc_pkg::*;

  logic cts_sync, cts_change, cts_ok;
  pol_e cts_pol;

  fc_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(cts_pin),
    .level(cts_sync), .change(cts_change)
  );

  fc_detect_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_i(cts_change), .clr_i(flag_clr),
    .flag_o(cts_chg_flag)
  );

  always_comb begin
    cts_pol = pol_e'(cts_act_high);
    cts_ok  = (cts_pol == POL_ACT_HIGH) ? cts_sync : !cts_sync;
  end

  fc_tx_gate u_gate (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_cts_en), .cts_ok(cts_ok),
    .tx_busy(tx_busy), .in_valid(tx_fifo_valid), .in_ready(tx_fifo_ready),
    .out_valid(shift_valid), .out_ready(shift_ready)
  );

  fc_rts_gen #(.CNT_W(CNT_W), .TRIG_W(TRIG_W)) u_rts (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_rts_en), .invert(rts_invert),
    .sw_req(sw_rts), .trig(rts_trig), .count(rx_count), .pin_o(rts_pin)
  );

  assign modem_irq = cts_chg_flag;
  assign cts_level = cts_sync;
  assign rts_level = rts_pin;

  assert_irq_tracks_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cts_chg_flag) |-> modem_irq);
endmodule

// File: tb/test_uart_flow_ctrl.sv
module test_uart_flow_ctrl;
  localparam int CNT_W  = 5;
  localparam int TRIG_W = 4;
  localparam int NV     = 12;
  // {auto, inv, sw, trig[3:0], count[4:0], expected pin}
  localparam logic [12:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b1, 4'd0,  5'd0,  1'b1},  // R3 sw=1
    {1'b0, 1'b0, 1'b0, 4'd0,  5'd20, 1'b0},  // R3 sw=0, count ignored
    {1'b0, 1'b1, 1'b0, 4'd0,  5'd0,  1'b1},  // R4 inverted manual
    {1'b1, 1'b0, 1'b0, 4'd4,  5'd3,  1'b1},  // R1 below
    {1'b1, 1'b0, 1'b0, 4'd4,  5'd4,  1'b0},  // R1 equal
    {1'b1, 1'b0, 1'b0, 4'd4,  5'd9,  1'b0},  // R1 above
    {1'b1, 1'b1, 1'b0, 4'd4,  5'd3,  1'b0},  // R4 inverted auto
    {1'b1, 1'b0, 1'b0, 4'd0,  5'd0,  1'b1},  // R2 empty
    {1'b1, 1'b0, 1'b0, 4'd0,  5'd1,  1'b0},  // R2 one byte
    {1'b1, 1'b0, 1'b1, 4'd15, 5'd14, 1'b1},  // R1 top level below
    {1'b1, 1'b0, 1'b1, 4'd15, 5'd15, 1'b0},  // R1 top level equal
    {1'b1, 1'b1, 1'b0, 4'd1,  5'd1,  1'b1}   // R4 inverted at level
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic auto_rts_en = 0, auto_cts_en = 0, rts_invert = 0, cts_act_high = 0;
  logic sw_rts = 0, flag_clr = 0, tx_fifo_valid = 0, shift_ready = 0;
  logic tx_busy = 0, cts_pin = 0;
  logic [TRIG_W-1:0] rts_trig = '0;
  logic [CNT_W-1:0]  rx_count = '0;
  logic tx_fifo_ready, shift_valid, rts_pin, cts_chg_flag, modem_irq;
  logic cts_level, rts_level;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  uart_flow_ctrl #(.CNT_W(CNT_W), .TRIG_W(TRIG_W)) i_uart_flow_ctrl (
    .clk(clk), .rst_n(rst_n), .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en),
    .rts_invert(rts_invert), .cts_act_high(cts_act_high), .sw_rts(sw_rts),
    .rts_trig(rts_trig), .flag_clr(flag_clr), .rx_count(rx_count),
    .tx_fifo_valid(tx_fifo_valid), .tx_fifo_ready(tx_fifo_ready),
    .shift_valid(shift_valid), .shift_ready(shift_ready), .tx_busy(tx_busy),
    .cts_pin(cts_pin), .rts_pin(rts_pin), .cts_chg_flag(cts_chg_flag),
    .modem_irq(modem_irq), .cts_level(cts_level), .rts_level(rts_level)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    chk("R12 rts_pin", rts_pin, 1'b0);
    chk("R12 cts_level", cts_level, 1'b0);
    chk("R12 flag", cts_chg_flag, 1'b0);
    rst_n = 1'b1;
    step(1);

    // RTS vector table
    for (int v = 0; v < NV; v++) begin
      auto_rts_en = VEC[v][12];
      rts_invert  = VEC[v][11];
      sw_rts      = VEC[v][10];
      rts_trig    = VEC[v][9:6];
      rx_count    = VEC[v][5:1];
      step(1);
      chk($sformatf("R1/R2/R3/R4 vec%0d", v), rts_pin, VEC[v][0]);
      chk("R11 rts_level", rts_level, rts_pin);
    end

    // Stream gate, CTS active low, pin low = active
    auto_cts_en = 1; tx_fifo_valid = 1; shift_ready = 1;
    #1;
    chk("R6 start allowed", shift_valid, 1'b1);
    chk("R8 pop on accept", tx_fifo_ready, 1'b1);
    shift_ready = 0; #1;
    chk("R8 valid without ready", shift_valid, 1'b1);
    chk("R8 no pop without ready", tx_fifo_ready, 1'b0);
    shift_ready = 1; tx_busy = 1; #1;
    chk("R7 busy blocks start", shift_valid, 1'b0);
    chk("R7 busy blocks pop", tx_fifo_ready, 1'b0);
    tx_busy = 0; tx_fifo_valid = 0; #1;
    chk("R8 empty no offer", shift_valid, 1'b0);
    tx_fifo_valid = 1;

    // CTS goes inactive (high) during a frame
    @(negedge clk);
    tx_busy = 1;
    cts_pin = 1;
    step(1);
    chk("R11 cts_level delay", cts_level, 1'b0);
    step(1);
    chk("R11 cts_level", cts_level, 1'b1);
    chk("R9 flag not yet", cts_chg_flag, 1'b0);
    tx_busy = 0; #1;
    chk("R6 blocked after frame", shift_valid, 1'b0);
    chk("R7 no pop after frame", tx_fifo_ready, 1'b0);
    step(1);
    chk("R9 flag set", cts_chg_flag, 1'b1);
    chk("R9 irq", modem_irq, 1'b1);
    step(3);
    chk("R9 sticky", cts_chg_flag, 1'b1);

    auto_cts_en = 0; #1;
    chk("R6 ignore when off", shift_valid, 1'b1);
    auto_cts_en = 1; cts_act_high = 1; #1;
    chk("R5 active high", shift_valid, 1'b1);
    cts_act_high = 0;

    flag_clr = 1;
    step(1);
    flag_clr = 0;
    chk("R10 clear", cts_chg_flag, 1'b0);

    // Set wins over clear
    cts_pin = 0;
    step(2);
    chk("R6 resumes when active", shift_valid, 1'b1);
    flag_clr = 1;
    step(1);
    flag_clr = 0;
    chk("R10 set wins", cts_chg_flag, 1'b1);
    flag_clr = 1;
    step(1);
    flag_clr = 0;
    chk("R10 clear again", cts_chg_flag, 1'b0);
    cts_act_high = 1; #1;
    chk("R5 low inactive when high-active", shift_valid, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule